// File: doc/BRIEF.md
# Packed SIMD Integer Execution Unit

This block is the arithmetic back end for packed integer instructions. It takes two operands of `DATA_W` bits (64 by default), treats them as four 16-bit word lanes or eight 8-bit byte lanes depending on the operation, and returns one result of the same width. An 8-bit opcode chooses among signed-word minimum, unsigned-byte minimum, byte sign-mask gathering, four flavours of 16x16 lane multiply (rounded high, unsigned high, signed high, low), and a full-width bitwise OR. Decode of the enclosing instruction, operand fetch and register write-back belong to the surrounding pipeline.

Operations enter on a valid/ready stream and leave on a valid/ready stream. An operation is taken when `in_valid` and `in_ready` are both high at a rising clock edge. A result is handed over when `out_valid` and `out_ready` are both high at a rising edge. While `out_valid` is high and `out_ready` is low, the whole pipeline freezes. The held result and its data stay steady, and `in_ready` drops so no new work enters. `in_ready` is high whenever the output stage is empty or is being drained in that cycle.

Every operation, the single-cycle mask gather included, leaves the unit exactly two accepting edges after it entered. Results therefore keep issue order under back-to-back issue. An opcode the unit does not recognise is accepted and then discarded. It leaves a bubble and produces no result.

Top module: `simd_exec_unit`

## Requirements
- R1: Opcode 8'hEA gives the per-word signed minimum: each 16-bit lane of the result is the smaller of the two operand lanes, compared as two's-complement values.
- R2: Opcode 8'hDA gives the per-byte unsigned minimum: each 8-bit lane of the result is the smaller of the two operand lanes, compared as unsigned values.
- R3: Opcode 8'hD7 places the most significant bit of byte k of `in_b` into result bit k, for k = 0 to 7, and sets every higher result bit to zero. `in_a` has no effect on this result.
- R4: Opcode 8'hB7 forms the signed 32-bit product of each word lane pair, adds 2^14, and returns bits 30:15 of that sum in the lane.
- R5: Opcode 8'hE4 returns bits 31:16 of the unsigned 16x16 product per word lane. Opcode 8'hE5 returns bits 31:16 of the signed 16x16 product per word lane.
- R6: Opcode 8'hD5 returns bits 15:0 of the 16x16 product per word lane.
- R7: Opcode 8'hEB returns the bitwise OR of `in_a` and `in_b` across all bits.
- R8: With `out_ready` held high, an operation accepted at edge t shows `out_valid` high after edge t+2, for every opcode. Results leave in the order they were accepted.
- R9: An accepted operation whose opcode is not one of the eight above produces no result, and the results around it are unchanged.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged at the next edge.
- R11: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low.
- R12: While `rst_n` is low, and right after it rises, `out_valid` is low and no earlier work is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit takes the offered operation at this edge |
| in_opc | input | 8 | Operation code |
| in_a | input | DATA_W | First operand (destination-side lanes) |
| in_b | input | DATA_W | Second operand (source-side lanes) |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the presented result |
| out_data | output | DATA_W | Result lanes, or the zero-extended byte mask |

## Verification
The bench builds the unit with its default `DATA_W` of 64. This gives four word lanes and eight byte lanes, so the sign-mask output fills exactly its low byte. The lane edges 8'h80/8'h7F and 16'h8000/16'h7FFF, and the full-scale products 16'hFFFF squared and 16'h8000 squared, are all reachable. A behavioural two-slot model is compared against the unit on every clock. Random opcodes include unrecognised values, and a random `out_ready` drives stalls at every pipeline occupancy. Directed steps cover the rounding overflow lane, the sign-boundary minimums, and a multi-cycle hold.

// File: rtl/simd_exec_pkg.sv
package simd_exec_pkg;

  localparam logic [7:0] OPC_MIN_SW   = 8'hEA;
  localparam logic [7:0] OPC_MIN_UB   = 8'hDA;
  localparam logic [7:0] OPC_SIGNMASK = 8'hD7;
  localparam logic [7:0] OPC_MULH_RND = 8'hB7;
  localparam logic [7:0] OPC_MULH_U   = 8'hE4;
  localparam logic [7:0] OPC_MULH_S   = 8'hE5;
  localparam logic [7:0] OPC_MUL_LO   = 8'hD5;
  localparam logic [7:0] OPC_OR       = 8'hEB;

  typedef enum logic [2:0] {
    K_MIN_SW,
    K_MIN_UB,
    K_SIGNMASK,
    K_MULH_RND,
    K_MULH_U,
    K_MULH_S,
    K_MUL_LO,
    K_OR
  } kind_e;

  typedef struct packed {
    logic  ok;
    kind_e kind;
  } dec_t;

  function automatic dec_t decode_opc(input logic [7:0] opc);
    dec_t d;
    d.ok   = 1'b1;
    d.kind = K_OR;
    unique case (opc)
      OPC_MIN_SW:   d.kind = K_MIN_SW;
      OPC_MIN_UB:   d.kind = K_MIN_UB;
      OPC_SIGNMASK: d.kind = K_SIGNMASK;
      OPC_MULH_RND: d.kind = K_MULH_RND;
      OPC_MULH_U:   d.kind = K_MULH_U;
      OPC_MULH_S:   d.kind = K_MULH_S;
      OPC_MUL_LO:   d.kind = K_MUL_LO;
      OPC_OR:       d.kind = K_OR;
      default:      d.ok   = 1'b0;
    endcase
    return d;
  endfunction

  function automatic logic is_mul(input kind_e k);
    return (k == K_MULH_RND) || (k == K_MULH_U) ||
           (k == K_MULH_S)   || (k == K_MUL_LO);
  endfunction

endpackage

// File: rtl/simd_op_decode.sv
module simd_op_decode
  import simd_exec_pkg::*;
#(
  parameter int OPC_W = 8
) (
  input  logic [OPC_W-1:0] opc,
  output logic             ok,
  output kind_e            kind
);

  dec_t d;

  always_comb begin
    d    = decode_opc(opc[7:0]);
    ok   = d.ok;
    kind = d.kind;
  end

endmodule

// File: rtl/simd_front.sv
module simd_front
  import simd_exec_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  localparam int WLANES = DATA_W / WORD_W,
  localparam int BLANES = DATA_W / BYTE_W,
  localparam int PROD_W = 2 * WORD_W
) (
  input  kind_e                    kind,
  input  logic [DATA_W-1:0]        a,
  input  logic [DATA_W-1:0]        b,
  output logic [DATA_W-1:0]        direct,
  output logic [WLANES*PROD_W-1:0] prods
);

  logic [DATA_W-1:0] min_w;
  logic [DATA_W-1:0] min_b;
  logic [BLANES-1:0] msb_gather;
  logic              sx;

  assign sx = (kind != K_MULH_U);

  for (genvar i = 0; i < WLANES; i++) begin : g_word
    logic        [WORD_W-1:0] wa;
    logic        [WORD_W-1:0] wb;
    logic signed [WORD_W:0]   xa;
    logic signed [WORD_W:0]   xb;
    logic signed [2*WORD_W+1:0] full;

    assign wa   = a[i*WORD_W +: WORD_W];
    assign wb   = b[i*WORD_W +: WORD_W];
    assign xa   = {sx & wa[WORD_W-1], wa};
    assign xb   = {sx & wb[WORD_W-1], wb};
    assign full = xa * xb;
    assign prods[i*PROD_W +: PROD_W] = full[PROD_W-1:0];
    assign min_w[i*WORD_W +: WORD_W] =
      ($signed(wa) < $signed(wb)) ? wa : wb;
  end

  for (genvar j = 0; j < BLANES; j++) begin : g_byte
    logic [BYTE_W-1:0] ba;
    logic [BYTE_W-1:0] bb;

    assign ba = a[j*BYTE_W +: BYTE_W];
    assign bb = b[j*BYTE_W +: BYTE_W];
    assign min_b[j*BYTE_W +: BYTE_W] = (ba < bb) ? ba : bb;
    assign msb_gather[j] = bb[BYTE_W-1];
  end

  always_comb begin
    unique case (kind)
      K_MIN_SW:   direct = min_w;
      K_MIN_UB:   direct = min_b;
      K_SIGNMASK: direct = {{(DATA_W-BLANES){1'b0}}, msb_gather};
      K_OR:       direct = a | b;
      default:    direct = '0;
    endcase
  end

endmodule

// File: rtl/simd_back.sv
module simd_back
  import simd_exec_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 16,
  localparam int WLANES = DATA_W / WORD_W,
  localparam int PROD_W = 2 * WORD_W
) (
  input  kind_e                    kind,
  input  logic [DATA_W-1:0]        direct,
  input  logic [WLANES*PROD_W-1:0] prods,
  output logic [DATA_W-1:0]        result
);

  localparam logic [PROD_W-1:0] RND_ADD = PROD_W'(1) << (WORD_W - 2);

  for (genvar i = 0; i < WLANES; i++) begin : g_lane
    logic [PROD_W-1:0] p;
    logic [PROD_W-1:0] pr;
    logic [WORD_W-1:0] lane;

    assign p  = prods[i*PROD_W +: PROD_W];
    assign pr = p + RND_ADD;

    always_comb begin
      unique case (kind)
        K_MULH_RND:         lane = pr[PROD_W-2 -: WORD_W];
        K_MULH_U, K_MULH_S: lane = p[PROD_W-1 -: WORD_W];
        K_MUL_LO:           lane = p[WORD_W-1:0];
        default:            lane = direct[i*WORD_W +: WORD_W];
      endcase
    end

    assign result[i*WORD_W +: WORD_W] = lane;
  end

endmodule

// File: rtl/simd_exec_unit.sv
module simd_exec_unit
  import simd_exec_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int OPC_W  = 8,
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OPC_W-1:0]  in_opc,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  localparam int WLANES = DATA_W / WORD_W;
  localparam int PROD_W = 2 * WORD_W;

  logic                     adv;
  logic                     dec_ok;
  kind_e                    dec_kind;
  logic [DATA_W-1:0]        f_direct;
  logic [WLANES*PROD_W-1:0] f_prods;

  logic                     s1_valid;
  kind_e                    s1_kind;
  logic [DATA_W-1:0]        s1_direct;
  logic [WLANES*PROD_W-1:0] s1_prods;
  logic [DATA_W-1:0]        b_result;

  logic                     o_valid;
  logic [DATA_W-1:0]        o_data;

  // one enable moves every stage together, so order is fixed by construction
  assign adv      = !(o_valid && !out_ready);
  assign in_ready = adv;

  simd_op_decode #(.OPC_W(OPC_W)) u_dec (
    .opc  (in_opc),
    .ok   (dec_ok),
    .kind (dec_kind)
  );

  simd_front #(
    .DATA_W (DATA_W),
    .WORD_W (WORD_W),
    .BYTE_W (BYTE_W)
  ) u_front (
    .kind   (dec_kind),
    .a      (in_a),
    .b      (in_b),
    .direct (f_direct),
    .prods  (f_prods)
  );

  // stage 1: lane-wise min / or / mask results and raw products
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_kind  <= K_OR;
    end else if (adv) begin
      s1_valid <= in_valid && dec_ok;
      s1_kind  <= dec_kind;
    end
  end

  always_ff @(posedge clk) begin
    if (adv && in_valid && dec_ok) begin
      s1_direct <= f_direct;
      s1_prods  <= is_mul(dec_kind) ? f_prods : '0;
    end
  end

  simd_back #(
    .DATA_W (DATA_W),
    .WORD_W (WORD_W)
  ) u_back (
    .kind   (s1_kind),
    .direct (s1_direct),
    .prods  (s1_prods),
    .result (b_result)
  );

  // stage 2: product slicing and rounding, output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
    end else if (adv) begin
      o_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (adv && s1_valid) begin
      o_data <= b_result;
    end
  end

  assign out_valid = o_valid;
  assign out_data  = o_data;

endmodule

// File: rtl/simd_exec_unit_chk.sv
module simd_exec_unit_chk
  import simd_exec_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int OPC_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OPC_W-1:0]  in_opc,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              s1_valid
);

  dec_t chk_dec;
  logic take_ok;
  logic take_none;

  assign chk_dec   = decode_opc(in_opc[7:0]);
  assign take_ok   = rst_n && in_valid && in_ready && chk_dec.ok;
  assign take_none = in_ready && !(in_valid && chk_dec.ok);

  // R8: accepted work appears two edges later when the output drains
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(take_ok, 2) && $past(rst_n) && $past(out_ready)) |-> out_valid);

  // R9: nothing usable offered means stage one stays empty
  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_none |=> !s1_valid);

  // R10: a held result does not move or change
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R11: an empty output stage never blocks the input
  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

endmodule

bind simd_exec_unit simd_exec_unit_chk #(
  .DATA_W (DATA_W),
  .OPC_W  (OPC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_opc    (in_opc),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .s1_valid  (s1_valid)
);

// File: tb/simd_exec_unit_tb_top.sv
`timescale 1ns/1ps
module simd_exec_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_opc = 8'h00;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  simd_exec_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_opc    (in_opc),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  function automatic bit known(input logic [7:0] o);
    return o inside {8'hEA, 8'hDA, 8'hD7, 8'hB7, 8'hE4, 8'hE5, 8'hD5, 8'hEB};
  endfunction

  function automatic string tag_of(input logic [7:0] o);
    case (o)
      8'hEA: return "R1";
      8'hDA: return "R2";
      8'hD7: return "R3";
      8'hB7: return "R4";
      8'hE4, 8'hE5: return "R5";
      8'hD5: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [63:0] expect_of(input logic [7:0] o,
                                            input logic [63:0] a,
                                            input logic [63:0] b);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 4; i++) begin
      longint sa, sb, ua, ub, p;
      sa = longint'($signed(a[16*i +: 16]));
      sb = longint'($signed(b[16*i +: 16]));
      ua = longint'(a[16*i +: 16]);
      ub = longint'(b[16*i +: 16]);
      case (o)
        8'hEA: r[16*i +: 16] = (sa < sb) ? a[16*i +: 16] : b[16*i +: 16];
        8'hB7: begin p = sa * sb + 16384; r[16*i +: 16] = 16'(p >>> 15); end
        8'hE4: begin p = ua * ub; r[16*i +: 16] = 16'(p >> 16); end
        8'hE5: begin p = sa * sb; r[16*i +: 16] = 16'(p >>> 16); end
        8'hD5: begin p = sa * sb; r[16*i +: 16] = 16'(p); end
        default: ;
      endcase
    end
    for (int j = 0; j < 8; j++) begin
      if (o == 8'hDA)
        r[8*j +: 8] = (a[8*j +: 8] < b[8*j +: 8]) ? a[8*j +: 8] : b[8*j +: 8];
    end
    if (o == 8'hD7) begin
      for (int j = 0; j < 8; j++) r[j] = b[8*j+7];
    end
    if (o == 8'hEB) r = a | b;
    return r;
  endfunction

  // two-slot behavioural model: [0] = entered last edge, [1] = on output
  bit          m_v [2];
  logic [63:0] m_d [2];
  string       m_t [2];
  bit          check_on = 1'b0;

  task automatic fail_line(input string req, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
    bad++;
    $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
  endtask

  always @(posedge clk) begin
    bit go;
    if (!rst_n) begin
      m_v[0] = 0; m_v[1] = 0;
    end else begin
      go = !(m_v[1] && !out_ready);
      if (go) begin
        m_v[1] = m_v[0]; m_d[1] = m_d[0]; m_t[1] = m_t[0];
        m_v[0] = in_valid && known(in_opc);
        m_d[0] = expect_of(in_opc, in_a, in_b);
        m_t[0] = tag_of(in_opc);
      end
    end
    #1;
    if (check_on) begin
      total++;
      if (out_valid !== m_v[1])
        fail_line(m_v[1] ? "R8" : "R9", "out_valid", 64'(out_valid), 64'(m_v[1]));
      if (m_v[1]) begin
        total++;
        if (out_data !== m_d[1])
          fail_line(m_t[1], "out_data", out_data, m_d[1]);
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (check_on) begin
      total++;
      if (in_ready !== !(m_v[1] && !out_ready))
        fail_line("R11", "in_ready", 64'(in_ready), 64'(!(m_v[1] && !out_ready)));
    end
  end

  task automatic issue(input bit v, input logic [7:0] o,
                       input logic [63:0] a, input logic [63:0] b, input bit rdy);
    @(negedge clk);
    in_valid  = v;
    in_opc    = o;
    in_a      = a;
    in_b      = b;
    out_ready = rdy;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", total, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0) fail_line("R12", "out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0) fail_line("R12", "out_valid after reset", 64'(out_valid), 64'd0);
    check_on = 1'b1;

    // R1 sign boundary, R2 unsigned boundary, R3 mask with junk in_a
    issue(1, 8'hEA, 64'h8000_7FFF_0001_FFFF, 64'h7FFF_8000_FFFF_0001, 1);
    issue(1, 8'hDA, 64'h807F_00FF_1234_5678, 64'h7F80_FF00_4321_8765, 1);
    issue(1, 8'hD7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_8080_0080_7F81, 1);
    // R4 overflow lane, R5 full-scale, R6 low half, R7 or
    issue(1, 8'hB7, 64'h8000_4000_FFFF_0003, 64'h8000_4000_0001_5555, 1);
    issue(1, 8'hE4, 64'hFFFF_8000_0002_1234, 64'hFFFF_8000_8000_0010, 1);
    issue(1, 8'hE5, 64'hFFFF_8000_0002_1234, 64'hFFFF_8000_8000_0010, 1);
    issue(1, 8'hD5, 64'hFFFF_8000_0101_1234, 64'hFFFF_0002_0101_0010, 1);
    issue(1, 8'hEB, 64'hF0F0_0000_1234_0000, 64'h0F0F_0000_0000_ABCD, 1);
    // R9 unknown opcode between known ones, R8 mask after a multiply
    issue(1, 8'h00, 64'h1, 64'h2, 1);
    issue(1, 8'hE5, 64'h0003_0003_0003_0003, 64'h7FFF_7FFF_7FFF_7FFF, 1);
    issue(1, 8'hD7, 64'h0, 64'h0000_0000_0000_0080, 1);
    issue(1, 8'hFF, 64'h1, 64'h2, 1);
    // R10 hold for several cycles with input offered
    issue(1, 8'hEB, 64'h1111, 64'h2222, 0);
    issue(1, 8'hEA, 64'h5, 64'h3, 0);
    issue(1, 8'hDA, 64'h5, 64'h3, 0);
    issue(1, 8'hDA, 64'h5, 64'h3, 1);
    issue(0, 8'h00, 64'h0, 64'h0, 1);
    issue(0, 8'h00, 64'h0, 64'h0, 1);

    for (int n = 0; n < 4000; n++) begin
      logic [7:0] o;
      logic [63:0] a, b;
      int pick;
      pick = int'($urandom_range(0, 9));
      case (pick)
        0: o = 8'hEA; 1: o = 8'hDA; 2: o = 8'hD7; 3: o = 8'hB7;
        4: o = 8'hE4; 5: o = 8'hE5; 6: o = 8'hD5; 7: o = 8'hEB;
        default: o = 8'($urandom);
      endcase
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if ($urandom_range(0, 7) == 0) a[15:0] = 16'h8000;
      if ($urandom_range(0, 7) == 0) b[15:0] = 16'h8000;
      issue($urandom_range(0, 3) != 0, o, a, b, $urandom_range(0, 9) < 7);
    end
    issue(0, 8'h00, 64'h0, 64'h0, 1);
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule